// File: doc/BRIEF.md
# Command-SPI Register Access Master

This block sits on the host side of a serial link to a tuner-style slave. It turns one register-access request into one framed SPI transaction. The request may be a read or a write. It may be a single-byte access or a burst, and a burst either holds the slave's address fixed or lets it step forward. Each transaction starts with an eight-byte command header protected by a 7-bit CRC. For a burst, the payload follows the header and eight filler bytes close the transfer. The slave answers in the same transfer, and the master inspects the answer for a fixed acknowledge code.

The requester presents a request with a one-cycle `req_valid` and then waits for a one-cycle `done`, which comes with `ack_err` when the acknowledge was wrong. While the transaction runs, burst write data is pulled byte by byte: `wr_take` marks the cycle in which the byte on `wr_byte` is consumed. Read data is pushed out on `rd_valid`/`rd_byte`. The serial clock runs in mode 0 at a rate set by `sclk_div`.

Top module: `cspi_reg_master`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sclk is 0, and busy and done are 0.
- R2: Single access header, sent MSB first. Byte 0 is a 0 start bit and then chip_id. Byte 1 is {0, write, 1, addr[10:6]}, where bit 7 = 0 means single and bit 5 (fix) is forced to 1. Byte 2 is {addr[5:0], 2'b00}. Byte 3 is the write byte for a write and 0x00 for a read. The upper nibble of byte 4 is 0.
- R3: Burst access header. Byte 1 is {1, write, fix, addr[10:6]}. Byte 2 is {addr[5:0], L[13:12]}, byte 3 is L[11:4], and the upper nibble of byte 4 is L[3:0]. Here L is the byte count minus one, given on req_len_m1.
- R4: The CRC is 7 bits with feedback mask 0x09 (x^7+x^3+1) and starts at zero. It runs MSB first over the first 36 header bits. The lower nibble of byte 4 carries CRC[6:3].
- R5: Byte 5 is {CRC[2:0], 0, 1, 1, 1, 1}, and header bytes 6 and 7 are 0xFF.
- R6: SPI mode 0. spi_mosi only changes while spi_sclk is low, and each high phase of spi_sclk lasts sclk_div+1 clock cycles.
- R7: spi_cs_n stays low for the whole transaction, and spi_sclk is low whenever spi_cs_n is high. A single access moves exactly 8 bytes. A burst of N bytes moves N+16 bytes.
- R8: Response byte 7 must equal 0x47. Otherwise ack_err is raised together with done.
- R9: For a single read with a good acknowledge, rd_valid pulses once together with done, and rd_byte holds response byte 6.
- R10: For a burst read with a good acknowledge, response bytes 8 through 8+N-1 come out in order, one rd_valid pulse each, before done. If the acknowledge is bad, no rd_valid pulse is given.
- R11: A burst write sends N payload bytes right after the header, each taken from wr_byte in a cycle flagged by wr_take, and then eight 0xFF bytes. During a burst read, the payload slots carry 0xFF.
- R12: busy is high from the cycle after acceptance until done. done is a single-cycle pulse. A request raised while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| chip_id | input | 7 | Slave identifier placed in header byte 0 |
| sclk_div | input | DIV_W | Serial clock half period minus one, in clk cycles |
| req_valid | input | 1 | Request strobe, accepted when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | 1 = burst, 0 = single byte |
| req_fix | input | 1 | Burst only: 1 = fixed slave address, 0 = incrementing |
| req_addr | input | ADDR_W | Register address |
| req_len_m1 | input | LEN_W | Burst byte count minus one |
| wr_byte | input | 8 | Write data byte offered by the requester |
| wr_take | output | 1 | wr_byte is consumed in this cycle |
| rd_valid | output | 1 | rd_byte carries a received data byte |
| rd_byte | output | 8 | Received data byte |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| ack_err | output | 1 | Acknowledge mismatch, valid with done |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the slave |
| spi_miso | input | 1 | Serial data from the slave |

## Verification
The hardest case to reach from the ports is a burst read whose acknowledge fails. The master still has to clock the full payload and the trailing filler, yet it must not pass a single payload byte on. The case only arises when a slave answers wrongly in one exact byte slot. The bench's slave model serves a programmable response per byte position, and it corrupts position 7 on selected transactions while all other bytes stay valid data. A second awkward case is a fresh request raised in the middle of a transfer. It is produced by pulsing req_valid with different fields while busy, and then checking that the captured frame is unchanged and that no second transfer starts.

// File: rtl/cspi_pkg.sv
`timescale 1ns/1ps
package cspi_pkg;
   localparam int BYTE_W     = 8;
   localparam int HDR_BYTES  = 8;
   localparam int TAIL_BYTES = 8;
   localparam int HDR_BITS   = 36;
   localparam int CRC_W      = 7;
   localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;
   localparam logic [BYTE_W-1:0] FILL_BYTE = 8'hFF;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOAD = 2'd1,
      ST_WAIT = 2'd2
   } seq_st_t;
endpackage

// File: rtl/cspi_crc.sv
`timescale 1ns/1ps
module cspi_crc #(
   parameter int DATA_W = 36,
   parameter int CRC_W  = 7,
   parameter logic [CRC_W-1:0] POLY = 7'h09
) (
   input  logic [DATA_W-1:0] data,
   output logic [CRC_W-1:0]  crc
);
   initial begin
      assert (DATA_W > 0 && CRC_W > 1) else $error("cspi_crc: bad widths");
   end

   // Bitwise MSB-first LFSR, unrolled over the whole data word.
   always_comb begin
      logic [CRC_W-1:0] r;
      logic             fb;
      r = '0;
      for (int i = DATA_W - 1; i >= 0; i--) begin
         fb = r[CRC_W-1] ^ data[i];
         r  = {r[CRC_W-2:0], 1'b0};
         if (fb) r = r ^ POLY;
      end
      crc = r;
   end
endmodule

// File: rtl/cspi_hdr_build.sv
`timescale 1ns/1ps
module cspi_hdr_build
   import cspi_pkg::*;
#(
   parameter int ADDR_W = 11,
   parameter int LEN_W  = 11
) (
   input  logic [6:0]        chip_id,
   input  logic              is_write,
   input  logic              is_burst,
   input  logic              fix_addr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [LEN_W-1:0]  len_m1,
   input  logic [7:0]        wdata,
   output logic [63:0]       hdr
);
   localparam int FRAME_ADDR_W = 11;
   localparam int FRAME_LEN_W  = 14;

   initial begin
      assert (ADDR_W >= 1 && ADDR_W <= FRAME_ADDR_W) else $error("cspi_hdr_build: ADDR_W");
      assert (LEN_W >= 1 && LEN_W <= FRAME_LEN_W) else $error("cspi_hdr_build: LEN_W");
   end

   logic [FRAME_ADDR_W-1:0] a_f;
   logic [FRAME_LEN_W-1:0]  l_f;
   logic [7:0]              mid_byte;
   logic                    fix_bit;
   logic [HDR_BITS-1:0]     body;
   logic [CRC_W-1:0]        crc;

   assign a_f      = FRAME_ADDR_W'(addr);
   assign l_f      = is_burst ? FRAME_LEN_W'(len_m1) : '0;
   assign fix_bit  = is_burst ? fix_addr : 1'b1;
   assign mid_byte = is_burst ? l_f[11:4] : (is_write ? wdata : 8'h00);

   assign body = {1'b0, chip_id,
                  is_burst, is_write, fix_bit, a_f[10:6],
                  a_f[5:0], l_f[13:12],
                  mid_byte,
                  l_f[3:0]};

   cspi_crc #(.DATA_W(HDR_BITS), .CRC_W(CRC_W), .POLY(CRC_POLY)) u_crc (
      .data (body),
      .crc  (crc)
   );

   assign hdr = {body, crc[6:3], crc[2:0], 5'b01111, FILL_BYTE, FILL_BYTE};
endmodule

// File: rtl/cspi_byte_shift.sv
`timescale 1ns/1ps
module cspi_byte_shift #(
   parameter int DIV_W     = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [7:0]       tx_byte,
   input  logic [DIV_W-1:0] div,
   input  logic             miso,
   output logic             sclk,
   output logic             mosi,
   output logic             done,
   output logic [7:0]       rx_byte
);
   initial begin
      assert (DIV_W >= 1) else $error("cspi_byte_shift: DIV_W");
   end

   logic [7:0]       tx_q, rx_q, tx_next, rx_next;
   logic [2:0]       nbit;
   logic [DIV_W-1:0] cnt;
   logic             act, sclk_q, done_q, out_bit;

   generate
      if (MSB_FIRST) begin : g_msb
         assign out_bit = tx_q[7];
         assign tx_next = {tx_q[6:0], 1'b0};
         assign rx_next = {rx_q[6:0], miso};
      end else begin : g_lsb
         assign out_bit = tx_q[0];
         assign tx_next = {1'b0, tx_q[7:1]};
         assign rx_next = {miso, rx_q[7:1]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q   <= '0;
         rx_q   <= '0;
         nbit   <= '0;
         cnt    <= '0;
         act    <= 1'b0;
         sclk_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (start && !act) begin
            act    <= 1'b1;
            tx_q   <= tx_byte;
            nbit   <= '0;
            cnt    <= div;
            sclk_q <= 1'b0;
         end else if (act) begin
            if (cnt != '0) begin
               cnt <= cnt - 1'b1;
            end else begin
               cnt <= div;
               if (!sclk_q) begin
                  sclk_q <= 1'b1;
                  rx_q   <= rx_next;
               end else begin
                  sclk_q <= 1'b0;
                  if (nbit == 3'd7) begin
                     act    <= 1'b0;
                     done_q <= 1'b1;
                  end else begin
                     nbit <= nbit + 1'b1;
                     tx_q <= tx_next;
                  end
               end
            end
         end
      end
   end

   assign sclk    = sclk_q;
   assign mosi    = act ? out_bit : 1'b1;
   assign done    = done_q;
   assign rx_byte = rx_q;

   // R6: data line holds while the clock is high
   a_r6_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
      sclk_q |-> $stable(mosi));
   // R6: clock parks low whenever no byte is in flight
   a_r6_sclk_park: assert property (@(posedge clk) disable iff (!rst_n)
      !act |-> !sclk_q);
   // R7: byte completion leaves the shifter idle
   a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> !act);
endmodule

// File: rtl/cspi_reg_master.sv
`timescale 1ns/1ps
module cspi_reg_master
   import cspi_pkg::*;
#(
   parameter int ADDR_W    = 11,
   parameter int MAX_BURST = 2048,
   parameter int DIV_W     = 8,
   parameter logic [7:0] ACK_CODE = 8'h47,
   localparam int LEN_W    = $clog2(MAX_BURST)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [6:0]        chip_id,
   input  logic [DIV_W-1:0]  sclk_div,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              req_burst,
   input  logic              req_fix,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LEN_W-1:0]  req_len_m1,
   input  logic [7:0]        wr_byte,
   output logic              wr_take,
   output logic              rd_valid,
   output logic [7:0]        rd_byte,
   output logic              busy,
   output logic              done,
   output logic              ack_err,
   output logic              spi_sclk,
   output logic              spi_cs_n,
   output logic              spi_mosi,
   input  logic              spi_miso
);
   localparam int CNT_W   = $clog2(MAX_BURST + HDR_BYTES + TAIL_BYTES);
   localparam int ACK_POS = HDR_BYTES - 1;
   localparam int RD_POS  = HDR_BYTES - 2;

   initial begin
      assert (MAX_BURST >= 2 && MAX_BURST <= 16384) else $error("cspi_reg_master: MAX_BURST");
   end

   seq_st_t           st;
   logic              write_q, burst_q, fix_q, ack_ok;
   logic [ADDR_W-1:0] addr_q;
   logic [LEN_W-1:0]  len_q;
   logic [7:0]        wdata_q, rd_cap;
   logic [CNT_W-1:0]  idx, pay_last, last_idx;
   logic              done_q, err_q, rdv_q;
   logic [7:0]        rdb_q;

   logic [63:0]       hdr;
   logic [2:0]        bsel;
   logic [7:0]        hdr_byte, tx_sel, sh_rx;
   logic              is_pay, sh_start, sh_done, ack_now, take_single;

   cspi_hdr_build #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_hdr (
      .chip_id  (chip_id),
      .is_write (write_q),
      .is_burst (burst_q),
      .fix_addr (fix_q),
      .addr     (addr_q),
      .len_m1   (len_q),
      .wdata    (wdata_q),
      .hdr      (hdr)
   );

   cspi_byte_shift #(.DIV_W(DIV_W), .MSB_FIRST(1'b1)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (sh_start),
      .tx_byte (tx_sel),
      .div     (sclk_div),
      .miso    (spi_miso),
      .sclk    (spi_sclk),
      .mosi    (spi_mosi),
      .done    (sh_done),
      .rx_byte (sh_rx)
   );

   assign pay_last = CNT_W'(HDR_BYTES) + CNT_W'(len_q);
   assign last_idx = burst_q ? (pay_last + CNT_W'(TAIL_BYTES)) : CNT_W'(HDR_BYTES - 1);
   assign is_pay   = burst_q && (idx >= CNT_W'(HDR_BYTES)) && (idx <= pay_last);
   assign bsel     = 3'd7 - idx[2:0];
   assign hdr_byte = hdr[{bsel, 3'b000} +: 8];
   assign ack_now  = (idx == CNT_W'(ACK_POS)) ? (sh_rx == ACK_CODE) : ack_ok;

   always_comb begin
      if (idx < CNT_W'(HDR_BYTES))  tx_sel = hdr_byte;
      else if (is_pay && write_q)   tx_sel = wr_byte;
      else                          tx_sel = FILL_BYTE;
   end

   assign sh_start    = (st == ST_LOAD);
   assign take_single = !burst_q && write_q && (idx == '0);
   assign wr_take     = (st == ST_LOAD) && (take_single || (is_pay && write_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         write_q <= 1'b0;
         burst_q <= 1'b0;
         fix_q   <= 1'b0;
         addr_q  <= '0;
         len_q   <= '0;
         wdata_q <= '0;
         rd_cap  <= '0;
         idx     <= '0;
         ack_ok  <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
         rdv_q   <= 1'b0;
         rdb_q   <= '0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         rdv_q  <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (req_valid) begin
                  write_q <= req_write;
                  burst_q <= req_burst;
                  fix_q   <= req_fix;
                  addr_q  <= req_addr;
                  len_q   <= req_len_m1;
                  idx     <= '0;
                  ack_ok  <= 1'b0;
                  st      <= ST_LOAD;
               end
            end
            ST_LOAD: begin
               if (take_single) wdata_q <= wr_byte;
               st <= ST_WAIT;
            end
            ST_WAIT: begin
               if (sh_done) begin
                  if (!burst_q && idx == CNT_W'(RD_POS)) rd_cap <= sh_rx;
                  if (idx == CNT_W'(ACK_POS)) ack_ok <= (sh_rx == ACK_CODE);
                  if (is_pay && !write_q && ack_now) begin
                     rdv_q <= 1'b1;
                     rdb_q <= sh_rx;
                  end
                  if (idx == last_idx) begin
                     st     <= ST_IDLE;
                     done_q <= 1'b1;
                     err_q  <= !ack_now;
                     if (!burst_q && !write_q && ack_now) begin
                        rdv_q <= 1'b1;
                        rdb_q <= rd_cap;
                     end
                  end else begin
                     idx <= idx + 1'b1;
                     st  <= ST_LOAD;
                  end
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy     = (st != ST_IDLE);
   assign spi_cs_n = (st == ST_IDLE);
   assign done     = done_q;
   assign ack_err  = err_q;
   assign rd_valid = rdv_q;
   assign rd_byte  = rdb_q;

   // R12: completion is a single-cycle pulse
   a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R8: acknowledge error only reported with completion
   a_r8_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      ack_err |-> done);
   // R7: no serial clock while deselected
   a_r7_sclk_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_sclk);
   // R10: burst read bytes arrive while the slave is still selected
   a_r10_rd_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !done) |-> !spi_cs_n);
   // R11: payload is pulled only inside a transaction
   a_r11_take_busy: assert property (@(posedge clk) disable iff (!rst_n)
      wr_take |-> !spi_cs_n);
endmodule

// File: tb/cspi_reg_master_bench.sv
`timescale 1ns/1ps
module cspi_reg_master_bench;
   localparam int ADDR_W    = 11;
   localparam int MAX_BURST = 2048;
   localparam int DIV_W     = 8;
   localparam int LEN_W     = $clog2(MAX_BURST);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic [6:0]        chip_id = 7'h35;
   logic [DIV_W-1:0]  sclk_div = 8'd1;
   logic              req_valid = 1'b0, req_write = 1'b0, req_burst = 1'b0, req_fix = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [LEN_W-1:0]  req_len_m1 = '0;
   logic [7:0]        wr_byte;
   logic              wr_take, rd_valid, busy, done, ack_err;
   logic [7:0]        rd_byte;
   logic              spi_sclk, spi_cs_n, spi_mosi, spi_miso;

   int total = 0;
   int bad = 0;

   cspi_reg_master #(.ADDR_W(ADDR_W), .MAX_BURST(MAX_BURST), .DIV_W(DIV_W)) u_cspi_reg_master (
      .clk(clk), .rst_n(rst_n), .chip_id(chip_id), .sclk_div(sclk_div),
      .req_valid(req_valid), .req_write(req_write), .req_burst(req_burst), .req_fix(req_fix),
      .req_addr(req_addr), .req_len_m1(req_len_m1), .wr_byte(wr_byte), .wr_take(wr_take),
      .rd_valid(rd_valid), .rd_byte(rd_byte), .busy(busy), .done(done), .ack_err(ack_err),
      .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // ---------------- slave model ----------------
   logic [7:0] resp [0:63];
   logic [7:0] wbuf [0:63];
   int         s_bit = 0, s_byte = 0;
   logic [7:0] s_in = '0;
   logic [7:0] mlog [$];

   always @(negedge spi_cs_n) begin
      s_bit  = 0;
      s_byte = 0;
   end
   always @(posedge spi_sclk) s_in = {s_in[6:0], spi_mosi};
   always @(negedge spi_sclk) begin
      s_bit++;
      if (s_bit == 8) begin
         mlog.push_back(s_in);
         s_bit = 0;
         s_byte++;
      end
   end
   always_comb begin
      logic [7:0] cur;
      cur = (s_byte < 64) ? resp[s_byte] : 8'hFF;
      spi_miso = cur[7 - (s_bit & 7)];
   end

   // ---------------- requester data source ----------------
   int   wr_idx = 0;
   logic took = 1'b0;
   assign wr_byte = wbuf[wr_idx & 63];

   // ---------------- per-clock reference comparison ----------------
   logic [7:0] exp_rd [$];
   logic [7:0] e_rd;
   logic       prev_sclk = 1'b0, prev_mosi = 1'b1;
   int         hi_run = 0, runs_checked = 0;

   always @(negedge clk) begin
      if (took) begin
         wr_idx++;
         took = 1'b0;
      end
      if (wr_take) took = 1'b1;
      if (rst_n) begin
         if (rd_valid) begin
            if (exp_rd.size() == 0) chk(1'b0, "R10 unexpected read byte", rd_byte, 0);
            else begin
               e_rd = exp_rd.pop_front();
               chk(rd_byte == e_rd, "R9 R10 read byte", rd_byte, e_rd);
            end
         end
         if (spi_cs_n && spi_sclk) chk(1'b0, "R7 clock while deselected", 1, 0);
         if (prev_sclk && spi_sclk && (spi_mosi != prev_mosi))
            chk(1'b0, "R6 data moved during high clock", spi_mosi, prev_mosi);
         if (spi_sclk) hi_run++;
         else if (prev_sclk) begin
            runs_checked++;
            if (hi_run != int'(sclk_div) + 1)
               chk(1'b0, "R6 high phase length", hi_run, int'(sclk_div) + 1);
            hi_run = 0;
         end
      end
      prev_sclk = spi_sclk;
      prev_mosi = spi_mosi;
   end

   function automatic logic [6:0] bcrc(input logic [35:0] d);
      logic [6:0] r;
      logic       t;
      r = '0;
      for (int i = 35; i >= 0; i--) begin
         t = r[6] ^ d[i];
         r = {r[5:0], 1'b0};
         if (t) r = r ^ 7'h09;
      end
      return r;
   endfunction

   task automatic run_txn(input bit w, input bit b, input bit fx, input logic [10:0] a,
                          input int n, input bit ackgood, input int seed, input bit poke);
      logic [7:0]  expf [$];
      logic [35:0] body;
      logic [6:0]  c;
      logic [13:0] lf;
      string       tag;
      int          guard;
      for (int k = 0; k < 64; k++) begin
         resp[k] = 8'((k * 29 + seed * 7 + 3) & 255);
         wbuf[k] = 8'((k * 53 + seed * 11 + 1) & 255);
      end
      resp[7] = ackgood ? 8'h47 : 8'h5A;
      mlog.delete();
      exp_rd.delete();
      wr_idx = 0;
      runs_checked = 0;
      if (!w && ackgood) begin
         if (b) for (int k = 0; k < n; k++) exp_rd.push_back(resp[8 + k]);
         else exp_rd.push_back(resp[6]);
      end
      lf   = b ? 14'(n - 1) : 14'd0;
      body = {1'b0, chip_id, b, w, (b ? fx : 1'b1), a[10:6], a[5:0], lf[13:12],
              (b ? lf[11:4] : (w ? wbuf[0] : 8'h00)), lf[3:0]};
      c = bcrc(body);
      expf.push_back(body[35:28]);
      expf.push_back(body[27:20]);
      expf.push_back(body[19:12]);
      expf.push_back(body[11:4]);
      expf.push_back({body[3:0], c[6:3]});
      expf.push_back({c[2:0], 5'b01111});
      expf.push_back(8'hFF);
      expf.push_back(8'hFF);
      if (b) begin
         for (int k = 0; k < n; k++) expf.push_back(w ? wbuf[k] : 8'hFF);
         for (int k = 0; k < 8; k++) expf.push_back(8'hFF);
      end

      @(negedge clk);
      req_valid  = 1'b1;
      req_write  = w;
      req_burst  = b;
      req_fix    = fx;
      req_addr   = a;
      req_len_m1 = LEN_W'(n - 1);
      @(negedge clk);
      req_valid = 1'b0;
      chk(busy && !spi_cs_n, "R12 busy and select after accept", busy, 1);
      if (poke) begin
         repeat (5) @(negedge clk);
         req_valid = 1'b1;
         req_write = ~w;
         req_burst = 1'b1;
         req_addr  = ~a;
         repeat (3) @(negedge clk);
         req_valid = 1'b0;
      end
      guard = 0;
      while (!done && guard < 40000) begin
         @(negedge clk);
         guard++;
      end
      chk(done, "R12 done pulse seen", done, 1);
      chk(ack_err == !ackgood, "R8 acknowledge check", ack_err, !ackgood);
      chk(spi_cs_n, "R7 select released at done", spi_cs_n, 1);
      @(negedge clk);
      chk(!done && !busy, "R12 done lasts one cycle", done, 0);
      chk(mlog.size() == expf.size(), "R7 transferred byte count", mlog.size(), expf.size());
      for (int k = 0; k < expf.size() && k < mlog.size(); k++) begin
         if (k < 4)      tag = b ? "R3 header byte" : "R2 header byte";
         else if (k < 5) tag = "R4 crc high bits";
         else if (k < 8) tag = "R5 header tail";
         else            tag = "R11 payload or filler";
         chk(mlog[k] == expf[k], tag, mlog[k], expf[k]);
      end
      chk(exp_rd.size() == 0, "R9 R10 all read bytes delivered", exp_rd.size(), 0);
      chk(runs_checked > 0, "R6 clock high phases measured", runs_checked, 1);
      if (poke) begin
         repeat (30) @(negedge clk);
         chk(spi_cs_n && !busy, "R12 request during busy ignored", busy, 0);
      end
   endtask

   initial begin
      #(4 * 200000);
      chk(1'b0, "watchdog expired", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int k = 0; k < 64; k++) begin
         resp[k] = 8'hFF;
         wbuf[k] = 8'h00;
      end
      repeat (4) @(negedge clk);
      chk(spi_cs_n == 1'b1, "R1 select idle after reset", spi_cs_n, 1);
      chk(spi_sclk == 1'b0, "R1 clock low after reset", spi_sclk, 0);
      chk(!busy && !done, "R1 busy and done clear", busy, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      sclk_div = 8'd1;
      run_txn(1'b1, 1'b0, 1'b0, 11'h5A3, 1, 1'b1, 1, 1'b0); // R2 single write
      run_txn(1'b0, 1'b0, 1'b0, 11'h7FF, 1, 1'b1, 2, 1'b0); // R9 single read
      run_txn(1'b0, 1'b0, 1'b0, 11'h001, 1, 1'b0, 3, 1'b0); // R8 single read, bad ack
      sclk_div = 8'd3;
      run_txn(1'b1, 1'b1, 1'b1, 11'h040, 5, 1'b1, 4, 1'b0); // R11 burst write fixed
      run_txn(1'b0, 1'b1, 1'b0, 11'h123, 4, 1'b1, 5, 1'b0); // R10 burst read incrementing
      run_txn(1'b0, 1'b1, 1'b0, 11'h2C7, 3, 1'b0, 6, 1'b0); // R10 burst read, bad ack
      sclk_div = 8'd0;
      run_txn(1'b1, 1'b1, 1'b0, 11'h3FE, 1, 1'b1, 7, 1'b0); // R3 one-byte burst
      run_txn(1'b0, 1'b1, 1'b1, 11'h610, 20, 1'b1, 8, 1'b0); // R3 longer length field
      sclk_div = 8'd2;
      run_txn(1'b1, 1'b0, 1'b0, 11'h0AB, 1, 1'b1, 9, 1'b1); // R12 request while busy

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule